// File: doc/BRIEF.md
# Prioritized 64-Source Interrupt Controller

This block sits between 64 level-sensitive interrupt lines and a processor. Each line is sampled into a pending bit on every clock. A source is a candidate when it is pending (or forced), enabled and not masked. Among the candidates, the controller picks a winner by comparing a programmable 8-bit level byte held for each source. It then drives the winner's priority level and a vector number to the processor.

Software reaches the controller through a byte-addressed register port that uses the low 8 address bits. Through it, software can:
- read the pending bits as two 32-bit halves;
- read and write the mask as two 32-bit halves;
- set or clear a single mask bit, or every mask bit, with a one-byte command;
- program each source's level byte, where a nonzero value also enables the source;
- fetch the current vector with an acknowledge read.

The winner is recomputed from register state every cycle, and the level and vector reach the processor through output registers.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A source is a candidate only when its pending or force bit is 1, its enable bit is 1 and its mask bit is 0. A pending source that is masked or disabled never wins, and neither does an enabled, unmasked source whose line is low.
- R2: The candidate with the largest level byte wins. When level bytes are equal, the higher source index wins.
- R3: `irq_vector` equals the winning index plus 64. With no candidate, `irq_vector` is 24 and `irq_level` is 0.
- R4: Each pending bit copies its input line on every clock. Offset 0x00 reads pending bits 63..32 and offset 0x04 reads bits 31..0. Writes to 0x00 and 0x04 change nothing.
- R5: Offset 0x08 reads and writes mask bits 63..32, and offset 0x0C reads and writes mask bits 31..0. A mask bit of 1 blocks its source.
- R6: Offset 0x40+n (n = 0..63) reads and writes the level byte of source n from data bits 7:0. Writing a nonzero byte enables source n, and writing zero disables it.
- R7: A write to 0x1C sets every mask bit when data bit 6 is 1. When data bit 6 is 0, it sets only the mask bit indexed by data bits 5:0.
- R8: A write to 0x1D clears every mask bit when data bit 6 is 1. When data bit 6 is 0, it clears only the mask bit indexed by data bits 5:0.
- R9: A read at 0xE0 returns the current `irq_vector` in bits 7:0. Reads at 0xE1..0xE7 and at every unmapped offset return 0.
- R10: After reset:
  - the mask is all ones;
  - pending, force, enable and all level bytes are zero;
  - `irq_vector` is 24 and `irq_level` is 0.
- R11: `irq_level` and `irq_vector` change on the first clock edge after the register state changes. `irq_level` carries bits 2:0 of the winning level byte.
- R12: The force words read as 0 at 0x10 and 0x14. Writes to 0x10, 0x14 or any unmapped offset change no register and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_in | input | 64 | Level-sensitive interrupt lines, bit n = source n |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_level | output | 3 | Priority level presented to the processor |
| irq_vector | output | 8 | Vector number presented to the processor |

## Verification
The bench goes after ties between equal level bytes. A design that scanned with strict greater-than would hand the win to the lower index. It drives a level byte above 7 and checks that only the low three bits appear, so a design that saturated the level or passed the full byte would fail. It checks that a source which is pending but disabled by a zero level byte, or pending but masked, never wins; a mis-ordered active equation would let such a source through. It also checks that writes to the pending, force and unmapped offsets leave both the read-back values and the outputs untouched, and that the outputs still hold their old value in the cycle right after a level write.

// File: rtl/irqc_pkg.sv
// Package: shared sizes, vector constants and register offsets for the
// prioritized interrupt controller. Assumes a byte-offset register port.
package irqc_pkg;
    localparam int SRC_N     = 64;
    localparam int IDX_W     = $clog2(SRC_N);
    localparam int LVL_W     = 8;
    localparam int OUT_LVL_W = 3;
    localparam int VEC_W     = 8;
    localparam int DATA_W    = 32;
    localparam int VEC_BASE  = 64;
    localparam int VEC_IDLE  = 24;

    localparam logic [7:0] OFF_PEND_HI = 8'h00;
    localparam logic [7:0] OFF_PEND_LO = 8'h04;
    localparam logic [7:0] OFF_MASK_HI = 8'h08;
    localparam logic [7:0] OFF_MASK_LO = 8'h0C;
    localparam logic [7:0] OFF_FRC_HI  = 8'h10;
    localparam logic [7:0] OFF_FRC_LO  = 8'h14;
    localparam logic [7:0] OFF_MSET    = 8'h1C;
    localparam logic [7:0] OFF_MCLR    = 8'h1D;
    localparam logic [7:0] OFF_SWACK   = 8'hE0;
    localparam logic [1:0] LVL_PAGE    = 2'b01;  // 0x40..0x7F
endpackage

// File: rtl/irqc_regs.sv
// Register file: pending capture, mask, force, per-source level/enable and
// the read multiplexer. Assumes SRC_N is 2*DATA_W and the level page spans
// one 64-byte window. Synchronous active-low reset.
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int N_SRC = SRC_N,
    parameter int LW    = LVL_W,
    parameter int DW    = DATA_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_SRC-1:0]         irq_in,
    input  logic [7:0]               bus_addr,
    input  logic                     bus_wr,
    input  logic [DW-1:0]            bus_wdata,
    input  logic [VEC_W-1:0]         vec_cur,
    output logic [DW-1:0]            bus_rdata,
    output logic [N_SRC-1:0]         pend_o,
    output logic [N_SRC-1:0]         force_o,
    output logic [N_SRC-1:0]         mask_o,
    output logic [N_SRC-1:0]         en_o,
    output logic [N_SRC-1:0][LW-1:0] lvl_o
);
    localparam int HALF = N_SRC / 2;
    localparam int SW   = $clog2(N_SRC);

    logic [N_SRC-1:0]         pend_q, force_q, mask_q, en_q;
    logic [N_SRC-1:0][LW-1:0] lvl_q;
    logic                     in_lvl_page;
    logic [SW-1:0]            page_idx;
    logic [SW-1:0]            cmd_idx;

    assign in_lvl_page = (bus_addr[7:6] == LVL_PAGE);
    assign page_idx    = bus_addr[SW-1:0];
    assign cmd_idx     = bus_wdata[SW-1:0];

    // Purpose: capture lines, apply register writes, hold force state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            force_q <= '0;
            mask_q  <= '1;
            en_q    <= '0;
            lvl_q   <= '0;
        end else begin
            pend_q  <= irq_in;
            force_q <= force_q;
            if (bus_wr) begin
                if (in_lvl_page) begin
                    lvl_q[page_idx] <= bus_wdata[LW-1:0];
                    en_q[page_idx]  <= (bus_wdata[LW-1:0] != '0);
                end else begin
                    case (bus_addr)
                        OFF_MASK_HI: mask_q[N_SRC-1:HALF] <= bus_wdata[HALF-1:0];
                        OFF_MASK_LO: mask_q[HALF-1:0]     <= bus_wdata[HALF-1:0];
                        OFF_MSET: begin
                            if (bus_wdata[6]) mask_q <= '1;
                            else              mask_q[cmd_idx] <= 1'b1;
                        end
                        OFF_MCLR: begin
                            if (bus_wdata[6]) mask_q <= '0;
                            else              mask_q[cmd_idx] <= 1'b0;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // Purpose: return the word addressed by bus_addr.
    always_comb begin
        bus_rdata = '0;
        if (in_lvl_page) begin
            bus_rdata = DW'(lvl_q[page_idx]);
        end else begin
            case (bus_addr)
                OFF_PEND_HI: bus_rdata = DW'(pend_q[N_SRC-1:HALF]);
                OFF_PEND_LO: bus_rdata = DW'(pend_q[HALF-1:0]);
                OFF_MASK_HI: bus_rdata = DW'(mask_q[N_SRC-1:HALF]);
                OFF_MASK_LO: bus_rdata = DW'(mask_q[HALF-1:0]);
                OFF_FRC_HI:  bus_rdata = DW'(force_q[N_SRC-1:HALF]);
                OFF_FRC_LO:  bus_rdata = DW'(force_q[HALF-1:0]);
                OFF_SWACK:   bus_rdata = DW'(vec_cur);
                default:     bus_rdata = '0;
            endcase
        end
    end

    assign pend_o  = pend_q;
    assign force_o = force_q;
    assign mask_o  = mask_q;
    assign en_o    = en_q;
    assign lvl_o   = lvl_q;

    AST_PEND_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> pend_q == $past(irq_in)); // R4
    AST_ENABLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && in_lvl_page) |=> en_q[$past(page_idx)] == ($past(bus_wdata[LW-1:0]) != '0)); // R6
    AST_MASK_ALL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_MSET && bus_wdata[6]) |=> mask_q == '1); // R7
    AST_MASK_ALL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_MCLR && bus_wdata[6]) |=> mask_q == '0); // R8
    AST_FORCE_WR_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == OFF_FRC_HI || bus_addr == OFF_FRC_LO)) |=> $stable(mask_q) && $stable(force_q)); // R12
endmodule

// File: rtl/irqc_arbiter.sv
// Arbiter: scans all sources in ascending order and keeps the candidate
// whose level byte is greater than or equal to the best so far, so equal
// levels resolve to the higher index. Purely combinational.
module irqc_arbiter
    import irqc_pkg::*;
#(
    parameter int N_SRC = SRC_N,
    parameter int LW    = LVL_W,
    parameter int IW    = IDX_W
) (
    input  logic [N_SRC-1:0]         cand,
    input  logic [N_SRC-1:0][LW-1:0] lvl,
    output logic                     hit,
    output logic [IW-1:0]            win_idx,
    output logic [LW-1:0]            win_lvl
);
    // Purpose: linear priority scan with ties to the higher index.
    always_comb begin
        hit     = 1'b0;
        win_idx = '0;
        win_lvl = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (cand[i] && lvl[i] >= win_lvl) begin
                hit     = 1'b1;
                win_idx = IW'(i);
                win_lvl = lvl[i];
            end
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
// Top: forms the candidate set from register state, runs the arbiter and
// registers the level and vector toward the processor. Assumes irq_in is
// already synchronous to clk. Synchronous active-low reset.
module prio_irq_ctrl
    import irqc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SRC_N-1:0]     irq_in,
    input  logic [7:0]           bus_addr,
    input  logic                 bus_wr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [OUT_LVL_W-1:0] irq_level,
    output logic [VEC_W-1:0]     irq_vector
);
    logic [SRC_N-1:0]            pend_w, force_w, mask_w, en_w, cand_w;
    logic [SRC_N-1:0][LVL_W-1:0] lvl_w;
    logic                        hit_w;
    logic [IDX_W-1:0]            win_idx_w;
    logic [LVL_W-1:0]            win_lvl_w;
    logic [VEC_W-1:0]            vec_q;
    logic [OUT_LVL_W-1:0]        lvl_q;

    irqc_regs #(.N_SRC(SRC_N), .LW(LVL_W), .DW(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .vec_cur   (vec_q),
        .bus_rdata (bus_rdata),
        .pend_o    (pend_w),
        .force_o   (force_w),
        .mask_o    (mask_w),
        .en_o      (en_w),
        .lvl_o     (lvl_w)
    );

    // Purpose: a source competes when raised, enabled and unmasked.
    assign cand_w = (pend_w | force_w) & en_w & ~mask_w;

    irqc_arbiter #(.N_SRC(SRC_N), .LW(LVL_W), .IW(IDX_W)) u_arb (
        .cand    (cand_w),
        .lvl     (lvl_w),
        .hit     (hit_w),
        .win_idx (win_idx_w),
        .win_lvl (win_lvl_w)
    );

    // Purpose: register the winner's level and vector for the processor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= VEC_W'(VEC_IDLE);
            lvl_q <= '0;
        end else if (hit_w) begin
            vec_q <= VEC_W'(VEC_BASE) + VEC_W'(win_idx_w);
            lvl_q <= win_lvl_w[OUT_LVL_W-1:0];
        end else begin
            vec_q <= VEC_W'(VEC_IDLE);
            lvl_q <= '0;
        end
    end

    assign irq_vector = vec_q;
    assign irq_level  = lvl_q;

    AST_WINNER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        hit_w |-> (pend_w[win_idx_w] | force_w[win_idx_w]) && !mask_w[win_idx_w] && lvl_w[win_idx_w] != '0); // R1
    AST_NONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(|cand_w) |=> irq_vector == VEC_W'(VEC_IDLE) && irq_level == '0); // R3
    AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_vector == VEC_W'(VEC_IDLE) || irq_vector >= VEC_W'(VEC_BASE)); // R3
endmodule

// File: tb/prio_irq_ctrl_tb.sv
// Scoreboard bench: driver tasks push expected items into a queue, the
// monitor pops them at the falling edge and compares with the design.
module prio_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_in = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq_level;
    logic [7:0]  irq_vector;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        string       req;
        bit          is_rd;
        logic [31:0] exp_rd;
        logic [2:0]  exp_lvl;
        logic [7:0]  exp_vec;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #4 clk = ~clk;  // 125 MHz

    prio_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_level(irq_level), .irq_vector(irq_vector)
    );

    // Monitor: compare every queued expectation away from the rising edge.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            checks++;
            if (it.is_rd) begin
                if (bus_rdata !== it.exp_rd) begin
                    failures++;
                    $display("FAIL %s read 0x%02h actual=0x%08h expected=0x%08h",
                             it.req, bus_addr, bus_rdata, it.exp_rd);
                end
            end else if (irq_level !== it.exp_lvl || irq_vector !== it.exp_vec) begin
                failures++;
                $display("FAIL %s outputs actual lvl=%0d vec=%0d expected lvl=%0d vec=%0d",
                         it.req, irq_level, irq_vector, it.exp_lvl, it.exp_vec);
            end
        end
    end

    task automatic settle();
        @(posedge clk); #1;
    endtask

    task automatic wr_bus(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        settle();
        bus_wr = 1'b0;
    endtask

    task automatic exp_rd(input string req, input logic [7:0] a, input logic [31:0] e);
        sb_item_t it;
        bus_addr = a;
        it.req = req; it.is_rd = 1'b1; it.exp_rd = e; it.exp_lvl = '0; it.exp_vec = '0;
        sb_q.push_back(it);
        settle();
    endtask

    task automatic exp_out(input string req, input logic [2:0] l, input logic [7:0] v);
        sb_item_t it;
        it.req = req; it.is_rd = 1'b0; it.exp_rd = '0; it.exp_lvl = l; it.exp_vec = v;
        sb_q.push_back(it);
        settle();
    endtask

    initial begin
        repeat (3) settle();
        rst_n = 1'b1;
        settle();
        // R10: reset state
        exp_out("R10", 3'd0, 8'd24);
        exp_rd("R10", 8'h08, 32'hFFFF_FFFF);
        exp_rd("R10", 8'h0C, 32'hFFFF_FFFF);
        exp_rd("R10", 8'h45, 32'h0);
        exp_rd("R10", 8'h04, 32'h0);
        exp_rd("R10", 8'hE0, 32'd24);

        // R1: pending and enabled but masked -> idle
        wr_bus(8'h45, 32'd3);
        irq_in[5] = 1'b1;
        settle(); settle();
        exp_out("R1", 3'd0, 8'd24);
        // R8: clear single mask bit 5 -> source 5 wins, R3 vector 69
        wr_bus(8'h1D, 32'd5);
        settle();
        exp_out("R8", 3'd3, 8'd69);
        // R4: pending read and ignored write
        exp_rd("R4", 8'h04, 32'h20);
        wr_bus(8'h04, 32'hFFFF_FFFF);
        exp_rd("R4", 8'h04, 32'h20);

        // R2: tie at level 3 between 5 and 40 -> 40 wins
        wr_bus(8'h68, 32'd3);
        irq_in[40] = 1'b1;
        wr_bus(8'h1D, 32'd40);
        settle();
        exp_out("R2", 3'd3, 8'd104);
        exp_rd("R4", 8'h00, 32'h100);

        // R2 / R11: level 14 wins, output carries low three bits (6)
        wr_bus(8'h4A, 32'd14);
        irq_in[10] = 1'b1;
        wr_bus(8'h1D, 32'd10);
        settle();
        exp_out("R11", 3'd6, 8'd74);
        // R7: mask source 10 again by index
        wr_bus(8'h1C, 32'd10);
        settle();
        exp_out("R7", 3'd3, 8'd104);
        exp_rd("R5", 8'h0C, 32'hFFFF_FFDF);
        exp_rd("R5", 8'h08, 32'hFFFF_FEFF);

        // R6: zero level disables source 40 -> 5 wins
        wr_bus(8'h68, 32'd0);
        settle();
        exp_out("R6", 3'd3, 8'd69);
        exp_rd("R6", 8'h68, 32'h0);
        exp_rd("R6", 8'h45, 32'd3);

        // R12: force and unmapped writes change nothing
        wr_bus(8'h10, 32'hFFFF_FFFF);
        wr_bus(8'h14, 32'hFFFF_FFFF);
        wr_bus(8'h30, 32'hFFFF_FFFF);
        settle();
        exp_out("R12", 3'd3, 8'd69);
        exp_rd("R12", 8'h10, 32'h0);
        exp_rd("R12", 8'h14, 32'h0);
        exp_rd("R12", 8'h0C, 32'hFFFF_FFDF);

        // R9: acknowledge read and zero reads
        exp_rd("R9", 8'hE0, 32'd69);
        exp_rd("R9", 8'hE3, 32'h0);
        exp_rd("R9", 8'h20, 32'h0);

        // R4 / R3: all lines low -> idle
        irq_in = '0;
        settle(); settle();
        exp_out("R3", 3'd0, 8'd24);

        // R5: word writes to the mask
        wr_bus(8'h0C, 32'h0);
        wr_bus(8'h08, 32'h0);
        exp_rd("R5", 8'h0C, 32'h0);
        exp_rd("R5", 8'h08, 32'h0);
        // R1: enabled and unmasked but not pending -> idle
        exp_out("R1", 3'd0, 8'd24);
        // R7 / R8: whole-mask commands
        wr_bus(8'h1C, 32'h40);
        exp_rd("R7", 8'h08, 32'hFFFF_FFFF);
        wr_bus(8'h1D, 32'h40);
        exp_rd("R8", 8'h0C, 32'h0);

        // R6: line 63 high but level zero -> idle
        irq_in[63] = 1'b1;
        settle(); settle();
        exp_out("R6", 3'd0, 8'd24);
        // R11: outputs still old right after the write edge, new one edge later
        wr_bus(8'h7F, 32'd7);
        exp_out("R11", 3'd0, 8'd24);
        exp_out("R11", 3'd7, 8'd127);
        // R2: higher level on lower index beats index 63
        irq_in[10] = 1'b1;
        settle(); settle();
        exp_out("R2", 3'd6, 8'd74);

        // R10: reset again restores idle and full mask
        rst_n = 1'b0;
        settle();
        rst_n = 1'b1;
        exp_out("R10", 3'd0, 8'd24);
        exp_rd("R10", 8'h7F, 32'h0);
        exp_rd("R10", 8'h0C, 32'hFFFF_FFFF);

        settle();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule